// File: doc/BRIEF.md
# Synchronous master serial receiver

This block is the receive half of a synchronous serial port that owns the shift clock. While receiving, it drives a clock onto the serial clock pin and takes one bit from the serial data pin on every falling edge of that clock. Bits go into a receive shift register, least significant bit first. A character is either 8 or 9 bits long. When the last bit of a character has been sampled, the block hands the completed character to a downstream receive buffer with a one-cycle push strobe. The buffer itself lives outside this block.

Software starts reception in one of two ways. A one-shot request receives a single character and then clears itself. A continuous enable keeps receiving characters back to back for as long as it stays high. If both are active, the one-shot request is consumed by the first character and reception carries on under the continuous enable. Dropping the continuous enable in the middle of a character stops the clock at once and throws the partial character away.

The downstream buffer can report an overrun. While it does, clock generation is frozen. A port enable gates the whole block: clearing it resets all internal state and forces the clock low. It also hands the data pin's output driver back to general-purpose control, because that driver is kept off while the port receives.

Top module: `sync_rx_master`

## Requirements
- R1: The clock output idles low. While receiving, each high phase and each low phase lasts baud_i+1 system clock cycles, so one full serial clock period is 2*(baud_i+1) system clocks.
- R2: A one-shot request (single_set_i pulse) with cont_en_i low produces exactly 8 rising edges of clk_o, or 9 when nine_bit_i=1. single_busy_o then returns to 0 in the same cycle as the push, and no further clocks follow.
- R3: Bits are assembled least significant first: the first bit sampled is char_o[0]. In 9-bit mode the ninth bit received is char_o[8]. In 8-bit mode char_o[8] is 0.
- R4: data_i is sampled on each falling edge of clk_o. push_o is high for exactly one cycle, in the same cycle in which clk_o goes low after the last bit of a character.
- R5: With cont_en_i held high, characters are received one after another without any software action in between, and each one is pushed.
- R6: If cont_en_i falls while single_busy_o is 0, clk_o is low in the next cycle. The partial character is never pushed, and no further clock edges occur.
- R7: If a one-shot request and cont_en_i are both active, single_busy_o clears when the first character is pushed and reception continues with the next character.
- R8: While overrun_i is high, clk_o holds its level and no push occurs. When overrun_i is released, the interrupted character completes with correct data.
- R9: With port_en_i low, clk_o is low, single_busy_o is 0, and single_set_i is ignored. With port_en_i high but no enable active, clk_o stays low.
- R10: data_oe_o is 0 whenever port_en_i is high. Otherwise it follows pin_oe_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_en_i | input | 1 | Port enable; low resets all state |
| single_set_i | input | 1 | One-cycle pulse requesting one character |
| cont_en_i | input | 1 | Continuous receive enable |
| nine_bit_i | input | 1 | 1 selects 9-bit characters, 0 selects 8-bit |
| baud_i | input | BAUD_W | Divider value; half period is baud_i+1 clocks |
| overrun_i | input | 1 | Downstream buffer overrun; pauses the clock |
| data_i | input | 1 | Serial data pin input |
| pin_oe_i | input | 1 | General-purpose output-enable request for the data pin |
| clk_o | output | 1 | Generated serial clock |
| data_oe_o | output | 1 | Data pin output driver enable |
| single_busy_o | output | 1 | One-shot request pending |
| push_o | output | 1 | One-cycle strobe: char_o is valid |
| char_o | output | 9 | Received character, bit 8 is the ninth bit |

## Verification
A bit counter that is off by one shows at the ports within one character. The number of rising edges of clk_o in one-shot mode comes out wrong, and the character on char_o is shifted against the bits that were driven. A wrong divider count shows in the very first high phase of clk_o. A missed abort or overrun hold shows within a few cycles, as a clock edge or push where none may appear. Stale state after the port enable is cleared shows on the next request, as extra clocks or a busy flag that stays set.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int unsigned MAX_BITS = 9;
  localparam int unsigned IDX_W    = $clog2(MAX_BITS);
  typedef logic [MAX_BITS-1:0] char_t;
  typedef logic [IDX_W-1:0]    idx_t;
endpackage

// File: rtl/sync_rx_baud.sv
module sync_rx_baud #(
  parameter int unsigned BAUD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              hold_i,
  input  logic [BAUD_W-1:0] baud_i,
  output logic              tick_o
);
  logic [BAUD_W-1:0] cnt_q;
  logic              at_end;

  assign at_end = (cnt_q >= baud_i);
  assign tick_o = !clr_i && !hold_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (!hold_i) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/sync_rx_ctrl.sv
module sync_rx_ctrl
  import sync_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic port_en_i,
  input  logic single_set_i,
  input  logic cont_en_i,
  input  logic nine_bit_i,
  input  logic overrun_i,
  input  logic tick_i,
  output logic abort_o,
  output logic hold_o,
  output logic sclk_o,
  output logic sample_o,
  output logic last_o,
  output idx_t idx_o,
  output logic single_busy_o
);
  logic single_q, cont_q, sclk_q;
  idx_t idx_q;
  logic go, cont_fall;
  idx_t last_idx;

  assign last_idx  = nine_bit_i ? idx_t'(MAX_BITS - 1) : idx_t'(MAX_BITS - 2);
  assign go        = port_en_i && (single_q || cont_en_i);
  assign cont_fall = cont_q && !cont_en_i;
  assign abort_o   = !go || cont_fall;
  assign hold_o    = overrun_i;
  assign sample_o  = tick_i && sclk_q && !abort_o;
  assign last_o    = (idx_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      single_q <= 1'b0;
      cont_q   <= 1'b0;
      sclk_q   <= 1'b0;
      idx_q    <= '0;
    end else if (!port_en_i) begin
      single_q <= 1'b0;
      cont_q   <= 1'b0;
      sclk_q   <= 1'b0;
      idx_q    <= '0;
    end else begin
      cont_q <= cont_en_i;
      if (abort_o) begin
        sclk_q <= 1'b0;
        idx_q  <= '0;
      end else if (tick_i) begin
        sclk_q <= !sclk_q;
        if (sclk_q) begin
          if (last_o) idx_q <= '0;
          else        idx_q <= idx_q + 1'b1;
        end
      end
      // set request wins over completion in the same cycle
      if (single_set_i)          single_q <= 1'b1;
      else if (sample_o && last_o) single_q <= 1'b0;
    end
  end

  assign sclk_o        = sclk_q;
  assign idx_o         = idx_q;
  assign single_busy_o = single_q;
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift
  import sync_rx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  sample_i,
  input  logic  last_i,
  input  idx_t  idx_i,
  input  logic  bit_i,
  input  logic  nine_bit_i,
  output logic  push_o,
  output char_t char_o
);
  char_t shreg_q, word, char_q;
  logic  push_q;

  always_comb begin
    word = shreg_q;
    word[idx_i] = bit_i;
    if (!nine_bit_i) word[MAX_BITS-1] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      char_q  <= '0;
      push_q  <= 1'b0;
    end else if (clr_i) begin
      shreg_q <= '0;
      char_q  <= '0;
      push_q  <= 1'b0;
    end else begin
      push_q <= sample_i && last_i;
      if (sample_i) shreg_q <= word;
      if (sample_i && last_i) char_q <= word;
    end
  end

  assign push_o = push_q;
  assign char_o = char_q;
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
  import sync_rx_pkg::*;
#(
  parameter int unsigned BAUD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_en_i,
  input  logic              single_set_i,
  input  logic              cont_en_i,
  input  logic              nine_bit_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic              overrun_i,
  input  logic              data_i,
  input  logic              pin_oe_i,
  output logic              clk_o,
  output logic              data_oe_o,
  output logic              single_busy_o,
  output logic              push_o,
  output logic [8:0]        char_o
);
  logic abort, hold, tick, sample, last;
  idx_t idx;
  char_t chr;

  sync_rx_baud #(.BAUD_W(BAUD_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (abort),
    .hold_i (hold),
    .baud_i (baud_i),
    .tick_o (tick)
  );

  sync_rx_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .port_en_i     (port_en_i),
    .single_set_i  (single_set_i),
    .cont_en_i     (cont_en_i),
    .nine_bit_i    (nine_bit_i),
    .overrun_i     (overrun_i),
    .tick_i        (tick),
    .abort_o       (abort),
    .hold_o        (hold),
    .sclk_o        (clk_o),
    .sample_o      (sample),
    .last_o        (last),
    .idx_o         (idx),
    .single_busy_o (single_busy_o)
  );

  sync_rx_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (!port_en_i),
    .sample_i   (sample),
    .last_i     (last),
    .idx_i      (idx),
    .bit_i      (data_i),
    .nine_bit_i (nine_bit_i),
    .push_o     (push_o),
    .char_o     (chr)
  );

  assign char_o    = chr;
  // receive owns the data pin: driver off while the port is enabled
  assign data_oe_o = pin_oe_i && !port_en_i;
endmodule

// File: rtl/sync_rx_master_chk.sv
module sync_rx_master_chk #(
  parameter int unsigned BAUD_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              port_en_i,
  input logic              single_set_i,
  input logic              cont_en_i,
  input logic              nine_bit_i,
  input logic [BAUD_W-1:0] baud_i,
  input logic              overrun_i,
  input logic              data_i,
  input logic              pin_oe_i,
  input logic              clk_o,
  input logic              data_oe_o,
  input logic              single_busy_o,
  input logic              push_o,
  input logic [8:0]        char_o
);
  assert_idle_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_en_i || (!single_busy_o && !cont_en_i)) |=> !clk_o);

  assert_push_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);

  assert_push_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> (!clk_o && $past(clk_o)));

  assert_abort_stops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cont_en_i) && !single_busy_o) |=> (!clk_o && !push_o));

  assert_overrun_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_i && port_en_i && cont_en_i) |=> ($stable(clk_o) && !push_o));

  assert_eight_bit_msb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && !nine_bit_i && $past(!nine_bit_i)) |-> !char_o[8]);

  always_comb begin
    if (rst_ni && port_en_i) assert_pin_off_R10: assert (!data_oe_o);
  end
endmodule

bind sync_rx_master sync_rx_master_chk #(.BAUD_W(BAUD_W)) u_chk (.*);

// File: tb/sim_sync_rx_master.sv
`timescale 1ns/1ps
module sim_sync_rx_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic port_en = 1'b0, single_set = 1'b0, cont_en = 1'b0, nine = 1'b0;
  logic [7:0] baud = 8'd0;
  logic overrun = 1'b0, data = 1'b0, pin_oe = 1'b0;
  logic sclk, data_oe, busy, push;
  logic [8:0] char_w;

  always #2.5 clk = ~clk;

  sync_rx_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .single_set_i(single_set),
    .cont_en_i(cont_en), .nine_bit_i(nine), .baud_i(baud), .overrun_i(overrun),
    .data_i(data), .pin_oe_i(pin_oe), .clk_o(sclk), .data_oe_o(data_oe),
    .single_busy_o(busy), .push_o(push), .char_o(char_w)
  );

  int checks = 0, errors = 0;
  int tx_idx = 0, rise_cnt = 0, toggles = 0, push_cnt = 0;
  int run_len = 0, hp = 0, cycles = 0;
  logic [31:0] tx_bits = '0;
  logic [8:0] last_char = '0;
  logic sclk_prev = 1'b0;
  bit done = 0;

  // {nine, baud, data}
  localparam logic [17:0] VEC [6] = '{
    {1'b0, 8'd0, 9'h1A5}, {1'b0, 8'd3, 9'h03C}, {1'b1, 8'd1, 9'h1C3},
    {1'b1, 8'd5, 9'h0FF}, {1'b0, 8'd2, 9'h081}, {1'b1, 8'd0, 9'h100}
  };

  // bit driven right after each observed rising edge of the serial clock
  always @(negedge clk) begin
    cycles++;
    if (sclk !== sclk_prev) begin
      toggles++;
      if (sclk_prev === 1'b1) hp = run_len;
      run_len = 1;
    end else run_len++;
    if (sclk === 1'b1 && sclk_prev === 1'b0) begin
      data = tx_bits[tx_idx];
      tx_idx++;
      rise_cnt++;
    end
    if (push === 1'b1) begin
      push_cnt++;
      last_char = char_w;
    end
    sclk_prev = sclk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_push(input int base, input string tag);
    int t = 0;
    while (push_cnt <= base && t < 5000) begin step(1); t++; end
    if (push_cnt <= base) chk(tag, 32'd0, 32'd1);
  endtask

  task automatic wait_rise(input int n);
    int t = 0;
    while (rise_cnt < n && t < 5000) begin step(1); t++; end
  endtask

  task automatic load(input logic [31:0] bits);
    tx_bits = bits; tx_idx = 0; rise_cnt = 0;
  endtask

  task automatic pulse_single();
    single_set = 1'b1; step(1); single_set = 1'b0;
  endtask

  initial begin
    int base, tg, rc;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R9 reset clk", sclk, 0);
    chk("R9 reset busy", busy, 0);
    chk("R4 reset push", push, 0);
    chk("R3 reset char", char_w, 0);
    port_en = 1'b1;
    step(2);

    // one-shot characters from the vector table
    foreach (VEC[i]) begin
      int nb;
      logic [8:0] d, exp;
      nine = VEC[i][17];
      baud = VEC[i][16:9];
      d    = VEC[i][8:0];
      nb   = nine ? 9 : 8;
      exp  = nine ? d : {1'b0, d[7:0]};
      load({23'd0, d});
      base = push_cnt;
      pulse_single();
      wait_push(base, "R4 push missing");
      chk("R3 char", last_char, exp);
      chk("R2 busy cleared", busy, 0);
      step((baud + 1) * 4 + 4);
      chk("R2 clock count", rise_cnt, nb);
      chk("R1 high phase", hp, baud + 1);
      chk("R1 idle low", sclk, 0);
    end

    // continuous back-to-back
    nine = 1'b0; baud = 8'd1;
    load({16'd0, 8'h3E, 8'hC7});
    base = push_cnt;
    cont_en = 1'b1;
    wait_push(base, "R5 first push");
    chk("R5 first char", last_char, 9'h0C7);
    wait_push(base + 1, "R5 second push");
    chk("R5 second char", last_char, 9'h03E);
    cont_en = 1'b0;
    step(2);
    chk("R6 clk low after stop", sclk, 0);

    // abort mid-character
    baud = 8'd2;
    load(32'h0000_00FF);
    cont_en = 1'b1;
    wait_rise(4);
    cont_en = 1'b0;
    step(2);
    chk("R6 clk low", sclk, 0);
    base = push_cnt; tg = toggles;
    step(60);
    chk("R6 no push", push_cnt, base);
    chk("R6 no edges", toggles, tg);

    // both enables
    baud = 8'd0; nine = 1'b1;
    load({14'd0, 9'h155, 9'h0AA});
    base = push_cnt;
    cont_en = 1'b1;
    pulse_single();
    chk("R7 busy set", busy, 1);
    wait_push(base, "R7 first push");
    chk("R7 busy cleared", busy, 0);
    chk("R7 first char", last_char, 9'h0AA);
    wait_push(base + 1, "R7 second push");
    chk("R7 second char", last_char, 9'h155);
    cont_en = 1'b0;
    step(3);

    // overrun pause
    nine = 1'b0; baud = 8'd1;
    load(32'h0000_005A);
    base = push_cnt;
    cont_en = 1'b1;
    wait_rise(3);
    overrun = 1'b1;
    step(1);
    tg = toggles; rc = rise_cnt;
    step(40);
    chk("R8 clock frozen", toggles, tg);
    chk("R8 no push", push_cnt, base);
    overrun = 1'b0;
    wait_push(base, "R8 resume push");
    chk("R8 char after resume", last_char, 9'h05A);
    cont_en = 1'b0;
    step(3);

    // port disable resets
    baud = 8'd3;
    load(32'h0);
    pulse_single();
    wait_rise(2);
    port_en = 1'b0;
    step(2);
    chk("R9 clk low port off", sclk, 0);
    chk("R9 busy cleared port off", busy, 0);
    pulse_single();
    port_en = 1'b1;
    tg = toggles;
    step(30);
    chk("R9 request ignored", busy, 0);
    chk("R9 no clocks idle", toggles, tg);

    // data pin driver
    pin_oe = 1'b1;
    step(1);
    chk("R10 driver off when enabled", data_oe, 0);
    port_en = 1'b0;
    step(1);
    chk("R10 driver follows request", data_oe, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule